// File: doc/BRIEF.md
# Page Column to Buffer Address Mapper

This block sits between a page-buffer access sequencer and the internal buffer RAM of a flash controller. Given a starting column inside a page and a byte count, it streams one internal buffer address per clock cycle. Columns below the page size address a contiguous main buffer directly. Columns at or above the page size fall into the spare area. The spare area is not contiguous. The page is divided into 512-byte chunks. Each chunk owns one spare buffer on a fixed 64-byte stride, and uses only an even-rounded share of the spare bytes. Any bytes past the last full share collect in the final buffer.

A two-bit geometry code selects the page and spare sizes. A spare-only mode treats the column as an offset from the start of the spare area, whatever its value. The spare index needs a division by the per-buffer share. A short seek phase does this by repeated subtraction before the first spare address is emitted, so no divider is built.

Top module: `nfc_spare_mapper`

## Requirements
- R1: After reset, `addr_valid` and `xfer_done` are low.
- R2: A transfer that starts at a column below the page size first emits exactly that column as the address. Each following cycle emits the next column while the column stays below the page size.
- R3: After the address for column page_size-1, the next address emitted in the same transfer is spare buffer 0 at offset 0, which is address 0x1000.
- R4: For a spare offset s, the index is idx = min(s / share, 7) and the address is (0x1000 + 64*idx + (s - idx*share)) mod 2^13. A start column c at or above the page size uses s = c - page_size.
- R5: `geom_sel` selects the page and spare sizes: 0 is 512/16, 1 is 2048/64, 2 is 4096/128 and 3 is 4096/218. The share is (spare / (page/512)) rounded down to an even number, which gives 16, 16, 16 and 26.
- R6: Spare offsets past seven full shares stay in buffer 7, and the in-buffer offset keeps growing.
- R7: With `spare_only` high, the start column is used as the spare offset s, even when it is below the page size.
- R8: A transfer of length L>0 emits exactly L addresses on L consecutive cycles. `addr_valid` is low at all other times.
- R9: `xfer_done` is a one-cycle pulse in the cycle after the last address, and it is never high together with `addr_valid`.
- R10: A start with length 0 emits no address and pulses `xfer_done` once.
- R11: A `start` pulse while a transfer is in progress is ignored. The running stream and its length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| start_col | input | COL_W | First page column (or spare offset in spare-only mode) |
| xfer_len | input | LEN_W | Number of addresses to emit |
| spare_only | input | 1 | Treat start_col as a spare offset |
| geom_sel | input | 2 | Page/spare geometry code, held stable during a transfer |
| buf_addr | output | ADDR_W | Internal buffer address |
| addr_valid | output | 1 | buf_addr is valid this cycle |
| xfer_done | output | 1 | One-cycle pulse after the last address |

## Verification
The bench builds the block with its default parameters: 13-bit columns, lengths and addresses, eight spare buffers, base 0x1000 and stride 64. With these values, all four geometry codes can be reached. This includes the uneven 218-byte spare, where offsets past 182 pile into buffer 7. Randomized transfers cover columns around the main/spare boundary and in spare-only mode. Directed cases cover the clamp, zero-length transfers and start pulses arriving mid-transfer.

// File: rtl/nfcmap_pkg.sv
package nfcmap_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SEEK  = 2'd1,
        PH_MAIN  = 2'd2,
        PH_SPARE = 2'd3
    } phase_e;

    // page bytes per geometry code
    function automatic int page_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 512;
            2'd1:    return 2048;
            default: return 4096;
        endcase
    endfunction

    // spare bytes per geometry code
    function automatic int spare_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 64;
            2'd2:    return 128;
            default: return 218;
        endcase
    endfunction

    // even-rounded spare share per 512-byte chunk
    function automatic int share_bytes(input logic [1:0] code);
        int chunks;
        chunks = page_bytes(code) / 512;
        return (spare_bytes(code) / chunks) & ~1;
    endfunction

endpackage

// File: rtl/nfcmap_geom.sv
module nfcmap_geom #(
    parameter int COL_W = 13
) (
    input  logic [1:0]       geom_sel,
    output logic [COL_W-1:0] page_size,
    output logic [COL_W-1:0] share
);
    logic [COL_W-1:0] page_tbl  [4];
    logic [COL_W-1:0] share_tbl [4];

    for (genvar k = 0; k < 4; k++) begin : g_tbl
        assign page_tbl[k]  = COL_W'(nfcmap_pkg::page_bytes(2'(k)));
        assign share_tbl[k] = COL_W'(nfcmap_pkg::share_bytes(2'(k)));
    end

    assign page_size = page_tbl[geom_sel];
    assign share     = share_tbl[geom_sel];
endmodule

// File: rtl/nfcmap_spare_fmt.sv
module nfcmap_spare_fmt #(
    parameter int COL_W      = 13,
    parameter int ADDR_W     = 13,
    parameter int NBUF       = 8,
    parameter int SPARE_BASE = 4096,
    parameter int STRIDE     = 64,
    localparam int IDX_W     = $clog2(NBUF)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [COL_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    logic [31:0] sum;
    assign sum  = 32'(SPARE_BASE) + 32'(idx) * 32'(STRIDE) + 32'(off);
    assign addr = sum[ADDR_W-1:0];
endmodule

// File: rtl/nfc_spare_mapper.sv
module nfc_spare_mapper #(
    parameter int COL_W      = 13,
    parameter int LEN_W      = 13,
    parameter int ADDR_W     = 13,
    parameter int NBUF       = 8,
    parameter int SPARE_BASE = 4096,
    parameter int STRIDE     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              spare_only,
    input  logic [1:0]        geom_sel,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              addr_valid,
    output logic              xfer_done
);
    import nfcmap_pkg::*;

    localparam int IDX_W = $clog2(NBUF);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBUF - 1);

    typedef struct packed {
        phase_e           phase;
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] left;
        logic [IDX_W-1:0] idx;
        logic [COL_W-1:0] off;
        logic             done;
    } state_t;

    state_t q, d;

    logic [COL_W-1:0]  page_size, share;
    logic [ADDR_W-1:0] spare_addr;

    nfcmap_geom #(.COL_W(COL_W)) u_geom (
        .geom_sel  (geom_sel),
        .page_size (page_size),
        .share     (share)
    );

    nfcmap_spare_fmt #(
        .COL_W(COL_W), .ADDR_W(ADDR_W), .NBUF(NBUF),
        .SPARE_BASE(SPARE_BASE), .STRIDE(STRIDE)
    ) u_fmt (
        .idx  (q.idx),
        .off  (q.off),
        .addr (spare_addr)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.left = xfer_len;
                    d.idx  = '0;
                    if (xfer_len == '0) begin
                        d.done = 1'b1;
                    end else if (spare_only) begin
                        d.phase = PH_SEEK;
                        d.off   = start_col;
                    end else if (start_col >= page_size) begin
                        d.phase = PH_SEEK;
                        d.off   = start_col - page_size;
                    end else begin
                        d.phase = PH_MAIN;
                        d.col   = start_col;
                    end
                end
            end
            PH_SEEK: begin
                // one subtraction per cycle replaces the divider
                if (q.idx != LAST_IDX && q.off >= share) begin
                    d.off = q.off - share;
                    d.idx = q.idx + 1'b1;
                end else begin
                    d.phase = PH_SPARE;
                end
            end
            PH_MAIN: begin
                if (q.left == LEN_W'(1)) begin
                    d.phase = PH_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.left = q.left - 1'b1;
                    if (q.col == page_size - 1'b1) begin
                        d.phase = PH_SPARE;
                        d.idx   = '0;
                        d.off   = '0;
                    end else begin
                        d.col = q.col + 1'b1;
                    end
                end
            end
            default: begin // PH_SPARE
                if (q.left == LEN_W'(1)) begin
                    d.phase = PH_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.left = q.left - 1'b1;
                    if (q.idx != LAST_IDX && q.off == share - 1'b1) begin
                        d.idx = q.idx + 1'b1;
                        d.off = '0;
                    end else begin
                        d.off = q.off + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, col: '0, left: '0, idx: '0, off: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign addr_valid = (q.phase == PH_MAIN) || (q.phase == PH_SPARE);
    assign buf_addr   = (q.phase == PH_MAIN) ? ADDR_W'(q.col) : spare_addr;
    assign xfer_done  = q.done;
endmodule

// File: rtl/nfc_spare_mapper_chk.sv
module nfc_spare_mapper_chk #(
    parameter int COL_W      = 13,
    parameter int ADDR_W     = 13,
    parameter int SPARE_BASE = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        geom_sel,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              addr_valid,
    input logic              xfer_done
);
    logic [ADDR_W-1:0] last_main;
    assign last_main = ADDR_W'(nfcmap_pkg::page_bytes(geom_sel) - 1);

    // R9
    valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && xfer_done));

    // R8
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_valid) |-> xfer_done);

    // R2
    main_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && $past(addr_valid) && $past(buf_addr) < ADDR_W'(SPARE_BASE)
         && $past(buf_addr) != last_main)
        |-> buf_addr == $past(buf_addr) + 1'b1);

    // R3
    cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && $past(addr_valid) && $past(buf_addr) == last_main)
        |-> buf_addr == ADDR_W'(SPARE_BASE));

    // R4
    spare_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && $past(addr_valid) && $past(buf_addr) >= ADDR_W'(SPARE_BASE))
        |-> buf_addr >= ADDR_W'(SPARE_BASE));
endmodule

bind nfc_spare_mapper nfc_spare_mapper_chk #(
    .COL_W(COL_W), .ADDR_W(ADDR_W), .SPARE_BASE(SPARE_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .geom_sel(geom_sel),
    .buf_addr(buf_addr), .addr_valid(addr_valid), .xfer_done(xfer_done)
);

// File: tb/nfc_spare_mapper_test.sv
module nfc_spare_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] start_col = '0;
    logic [12:0] xfer_len = '0;
    logic        spare_only = 1'b0;
    logic [1:0]  geom_sel = '0;
    logic [12:0] buf_addr;
    logic        addr_valid;
    logic        xfer_done;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    nfc_spare_mapper uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .xfer_len(xfer_len), .spare_only(spare_only), .geom_sel(geom_sel),
        .buf_addr(buf_addr), .addr_valid(addr_valid), .xfer_done(xfer_done)
    );

    function automatic int f_page(int code);
        return (code == 0) ? 512 : (code == 1) ? 2048 : 4096;
    endfunction
    function automatic int f_share(int code);
        return (code == 3) ? 26 : 16;
    endfunction
    function automatic int f_spare_off(int code, bit so, int col, int i);
        if (so) return col + i;
        return col + i - f_page(code);
    endfunction
    function automatic int f_addr(int code, bit so, int col, int i);
        int s, idx;
        if (!so && col + i < f_page(code)) return col + i;
        s   = f_spare_off(code, so, col, i);
        idx = s / f_share(code);
        if (idx > 7) idx = 7;
        return (4096 + 64 * idx + s - idx * f_share(code)) & 13'h1FFF;
    endfunction
    function automatic string f_tag(int code, bit so, int col, int i);
        if (so) return "R7";
        if (col + i < f_page(code)) return "R2";
        if (col < f_page(code)) return "R3";
        if (f_spare_off(code, so, col, i) >= 7 * f_share(code)) return "R6";
        return "R4";
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_xfer(input int code, input bit so, input int col, input int len,
                            input bit poke, input string tag_ovr);
        int n = 0;
        bit prev_v = 1'b0;
        bit seen_done = 1'b0;
        @(negedge clk);
        geom_sel = 2'(code); spare_only = so; start_col = 13'(col);
        xfer_len = 13'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < len + 40; cyc++) begin
            if (addr_valid) begin
                chk(int'(buf_addr) == f_addr(code, so, col, n),
                    (tag_ovr != "") ? tag_ovr : f_tag(code, so, col, n),
                    int'(buf_addr), f_addr(code, so, col, n));
                n++;
                if (poke && n == 2) begin
                    start_col = 13'(col + 5); xfer_len = 13'd1; start = 1'b1;
                end else begin
                    start = 1'b0;
                end
            end
            if (xfer_done) begin
                // R9: done right after last address, never with valid
                chk(!addr_valid && (prev_v || len == 0), "R9",
                    int'(addr_valid), 0);
                seen_done = 1'b1;
                break;
            end
            prev_v = addr_valid;
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen_done, "R9", int'(seen_done), 1);
        // R8 / R10 / R11: exact address count
        chk(n == len, poke ? "R11" : (len == 0 ? "R10" : "R8"), n, len);
        @(negedge clk);
        chk(!xfer_done && !addr_valid, "R9", int'(xfer_done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        chk(!addr_valid && !xfer_done, "R1", int'(addr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!addr_valid && !xfer_done, "R1", int'(xfer_done), 0);

        run_xfer(1, 1'b0, 2040, 20, 1'b0, "");   // R3 crossing
        run_xfer(0, 1'b0, 510, 10, 1'b0, "");    // R3 small page
        run_xfer(3, 1'b1, 26, 1, 1'b0, "R5");    // R5 share 26 -> 0x1040
        run_xfer(2, 1'b1, 47, 3, 1'b0, "R5");    // R5 share 16 buffer step
        run_xfer(3, 1'b1, 200, 18, 1'b0, "");    // R6 clamp
        run_xfer(3, 1'b0, 4096 + 210, 8, 1'b0, ""); // R6 column form
        run_xfer(1, 1'b1, 5, 4, 1'b0, "R7");     // R7 low column in spare mode
        run_xfer(0, 1'b0, 100, 0, 1'b0, "");     // R10
        run_xfer(2, 1'b0, 4090, 12, 1'b1, "");   // R11 poke
        run_xfer(3, 1'b1, 20, 10, 1'b1, "");     // R11 poke in spare

        for (int t = 0; t < 60; t++) begin
            int code, pg, sp, col, len;
            bit so;
            code = int'($urandom_range(0, 3));
            pg   = f_page(code);
            sp   = (code == 0) ? 16 : (code == 1) ? 64 : (code == 2) ? 128 : 218;
            so   = ($urandom_range(0, 3) == 0);
            if (so) col = int'($urandom_range(0, sp + 15));
            else    col = int'($urandom_range(pg - 40, pg + sp - 1));
            len  = int'($urandom_range(1, 40));
            run_xfer(code, so, col, len, 1'b0, "");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule